// File: doc/BRIEF.md
# External Interrupt Drain Controller

This block sits between an external interrupt request line and the dispatch stage of an in-order-completing core. It accepts a level-sensitive request and, while interrupts are enabled, freezes dispatch at once. It then waits until every instruction already in flight has retired from the completion buffer before it reports that the external interrupt exception is taken. Draining the buffer first means that an instruction which faults on its own is serviced ahead of the external interrupt. The request line has to stay high until the take pulse appears. If the request falls or an instruction fault arrives during the drain, the controller gives up and drops back to idle. Once the handler is running, the request may be released.

The controller has three named states. In **IDLE** it waits for a qualified request. In **DRAIN** dispatch is held while the completion buffer empties. **TAKE** lasts one cycle, carries the take pulse and the vector, and is always followed by IDLE.

The transitions are:
- **IDLE→DRAIN** on a qualified request with no instruction fault that cycle.
- **DRAIN→TAKE** when the buffer is empty, the request is still qualified and no fault occurs.
- **DRAIN→IDLE (abort)** when an instruction fault occurs.
- **DRAIN→IDLE (withdraw)** when the qualified request falls.
- **TAKE→IDLE** unconditionally.

The handler vector is offset 0x500 from one of two bases. A base-select input chooses which one.

Top module: `xirq_drain_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `stall_o` and `take_o` are 0 and the controller is in IDLE.
- R2: While `irq_en_i` is 0, a high `irq_req_i` has no effect: `stall_o` and `take_o` stay 0 even with the buffer empty.
- R3: In IDLE, a qualified request (`irq_req_i`=1 and `irq_en_i`=1) with `insn_exc_i`=0 raises `stall_o` in the same cycle, and the controller enters DRAIN at the next clock edge.
- R4: In DRAIN, while `cbuf_empty_i` is 0, `stall_o` stays 1 and `take_o` stays 0.
- R5: In DRAIN, when `cbuf_empty_i`=1 with a qualified request and no instruction fault, the next cycle is TAKE. In TAKE, `take_o`=1 and `stall_o`=1.
- R6: In TAKE, `vec_o` is 32'hFFF0_0500 when `hi_base_i`=1 and 32'h0000_0500 when `hi_base_i`=0.
- R7: If the qualified request falls during DRAIN, the controller returns to IDLE at the next edge. `stall_o` is then released and no take follows.
- R8: An instruction fault (`insn_exc_i`=1) during DRAIN returns the controller to IDLE with no take, even if the buffer is empty in the same cycle. In the following cycle the request is evaluated again from IDLE.
- R9: In IDLE, a qualified request in a cycle where `insn_exc_i`=1 neither raises `stall_o` nor starts a drain.
- R10: TAKE lasts exactly one cycle and is followed by IDLE, so `take_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 1 | Level-sensitive external interrupt request |
| irq_en_i | input | 1 | Interrupts-enabled bit |
| hi_base_i | input | 1 | Vector base select (1 = high base) |
| cbuf_empty_i | input | 1 | Completion buffer holds no instructions |
| insn_exc_i | input | 1 | An in-flight instruction raised its own exception |
| stall_o | output | 1 | Hold off dispatch of new instructions |
| take_o | output | 1 | One-cycle pulse: external interrupt taken |
| vec_o | output | 32 | Handler vector address |

## Verification
The main path is driven with a buffer that stays busy for several cycles before it empties. This is repeated under both base selections, which separates a premature take from a correct one and confirms both vector values. A request held high with interrupts disabled and the buffer already empty shows whether the enable gate really blocks the request. A request withdrawn mid-drain and a fault raised on the same cycle the buffer empties distinguish the two abort routes from the take route. The fault case is followed by a retake, which shows that re-evaluation from idle works. A fault that coincides with a fresh request in idle checks that the stall is held back.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_TAKE  = 2'd2
    } xirq_state_e;

    localparam int unsigned XIRQ_VEC_W      = 32;
    localparam logic [31:0] XIRQ_HI_BASE    = 32'hFFF0_0000;
    localparam logic [31:0] XIRQ_LO_BASE    = 32'h0000_0000;
    localparam logic [31:0] XIRQ_VEC_OFFSET = 32'h0000_0500;
endpackage

// File: rtl/xirq_req_qual.sv
module xirq_req_qual (
    input  logic req_i,
    input  logic en_i,
    input  logic exc_i,
    output logic qual_o,
    output logic start_o
);
    // A request counts only while interrupts are enabled.
    assign qual_o  = req_i & en_i;
    // Starting a drain also needs no competing instruction fault.
    assign start_o = req_i & en_i & ~exc_i;
endmodule

// File: rtl/xirq_vec_gen.sv
module xirq_vec_gen #(
    parameter int unsigned       VEC_W   = 32,
    parameter logic [VEC_W-1:0]  HI_BASE = '1,
    parameter logic [VEC_W-1:0]  LO_BASE = '0,
    parameter logic [VEC_W-1:0]  OFFSET  = '0
) (
    input  logic             hi_sel_i,
    output logic [VEC_W-1:0] vec_o
);
    logic [VEC_W-1:0] base;

    always_comb begin
        base  = hi_sel_i ? HI_BASE : LO_BASE;
        vec_o = base | OFFSET;
    end
endmodule

// File: rtl/xirq_drain_ctrl.sv
module xirq_drain_ctrl
    import xirq_pkg::*;
#(
    parameter int unsigned       VEC_W      = XIRQ_VEC_W,
    parameter logic [VEC_W-1:0]  HI_BASE    = XIRQ_HI_BASE,
    parameter logic [VEC_W-1:0]  LO_BASE    = XIRQ_LO_BASE,
    parameter logic [VEC_W-1:0]  VEC_OFFSET = XIRQ_VEC_OFFSET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req_i,
    input  logic             irq_en_i,
    input  logic             hi_base_i,
    input  logic             cbuf_empty_i,
    input  logic             insn_exc_i,
    output logic             stall_o,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o
);
    xirq_state_e state_q, state_d;
    logic        qual, start;

    xirq_req_qual u_qual (
        .req_i   (irq_req_i),
        .en_i    (irq_en_i),
        .exc_i   (insn_exc_i),
        .qual_o  (qual),
        .start_o (start)
    );

    xirq_vec_gen #(
        .VEC_W   (VEC_W),
        .HI_BASE (HI_BASE),
        .LO_BASE (LO_BASE),
        .OFFSET  (VEC_OFFSET)
    ) u_vec (
        .hi_sel_i (hi_base_i),
        .vec_o    (vec_o)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (insn_exc_i)        state_d = ST_IDLE;   // abort: fault wins
                else if (!qual)        state_d = ST_IDLE;   // withdraw
                else if (cbuf_empty_i) state_d = ST_TAKE;
            end
            ST_TAKE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stall_o = 1'b0;
        take_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  stall_o = start;     // freeze in the detection cycle
            ST_DRAIN: stall_o = 1'b1;
            ST_TAKE: begin
                stall_o = 1'b1;
                take_o  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xirq_drain_chk.sv
module xirq_drain_chk #(
    parameter int unsigned VEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req_i,
    input logic             cbuf_empty_i,
    input logic             insn_exc_i,
    input logic             stall_o,
    input logic             take_o,
    input logic [VEC_W-1:0] vec_o
);
    // R5: a take is always accompanied by the dispatch stall
    a_r5_take_with_stall: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> stall_o);

    // R5: a take follows a cycle in which the buffer was seen empty
    a_r5_take_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(cbuf_empty_i));

    // R10: take is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R6: the vector carries the fixed offset
    a_r6_vec_offset: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_o[11:0] == 12'h500));

    // R8: a fault while draining prevents a take in the next cycle
    a_r8_fault_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !take_o && insn_exc_i) |=> !take_o);

    // R7: a withdrawn request while draining prevents a take in the next cycle
    a_r7_withdraw_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !take_o && !irq_req_i) |=> !take_o);
endmodule

bind xirq_drain_ctrl xirq_drain_chk #(.VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req_i    (irq_req_i),
    .cbuf_empty_i (cbuf_empty_i),
    .insn_exc_i   (insn_exc_i),
    .stall_o      (stall_o),
    .take_o       (take_o),
    .vec_o        (vec_o)
);

// File: tb/tb_xirq_drain_ctrl.sv
module tb_xirq_drain_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq_req_i, irq_en_i, hi_base_i, cbuf_empty_i, insn_exc_i;
    logic        stall_o, take_o;
    logic [31:0] vec_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;   // 125 MHz

    xirq_drain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
        .hi_base_i(hi_base_i), .cbuf_empty_i(cbuf_empty_i), .insn_exc_i(insn_exc_i),
        .stall_o(stall_o), .take_o(take_o), .vec_o(vec_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // advance to the next negedge and let outputs settle
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic idle_inputs();
        irq_req_i = 0; irq_en_i = 1; cbuf_empty_i = 0; insn_exc_i = 0;
    endtask

    task automatic t_reset();
        idle_inputs();
        hi_base_i = 0;
        rst_n = 0;
        tick(); tick();
        settle();
        chk("R1", "stall in reset", {31'b0, stall_o}, 32'd0);
        chk("R1", "take in reset", {31'b0, take_o}, 32'd0);
        rst_n = 1;
        tick(); settle();
        chk("R1", "stall after reset", {31'b0, stall_o}, 32'd0);
        chk("R1", "take after reset", {31'b0, take_o}, 32'd0);
    endtask

    task automatic t_basic(input logic hi);
        hi_base_i = hi;
        tick(); irq_req_i = 1; irq_en_i = 1; cbuf_empty_i = 0; settle();
        chk("R3", "immediate stall", {31'b0, stall_o}, 32'd1);
        chk("R3", "no take yet", {31'b0, take_o}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            tick(); settle();
            chk("R4", "stall held in drain", {31'b0, stall_o}, 32'd1);
            chk("R4", "no take while busy", {31'b0, take_o}, 32'd0);
        end
        tick(); cbuf_empty_i = 1; settle();
        chk("R4", "no take in empty cycle", {31'b0, take_o}, 32'd0);
        tick(); irq_req_i = 0; settle();
        chk("R5", "take pulse", {31'b0, take_o}, 32'd1);
        chk("R5", "stall in take", {31'b0, stall_o}, 32'd1);
        chk("R6", "vector", vec_o, hi ? 32'hFFF0_0500 : 32'h0000_0500);
        tick(); cbuf_empty_i = 0; settle();
        chk("R10", "take ends", {31'b0, take_o}, 32'd0);
        chk("R10", "back to idle", {31'b0, stall_o}, 32'd0);
    endtask

    task automatic t_disabled();
        tick(); irq_req_i = 1; irq_en_i = 0; cbuf_empty_i = 1;
        for (int i = 0; i < 4; i++) begin
            settle();
            chk("R2", "no stall when disabled", {31'b0, stall_o}, 32'd0);
            chk("R2", "no take when disabled", {31'b0, take_o}, 32'd0);
            tick();
        end
        idle_inputs();
    endtask

    task automatic t_withdraw();
        tick(); irq_req_i = 1; irq_en_i = 1; cbuf_empty_i = 0;
        tick();                       // DRAIN
        tick(); irq_req_i = 0; settle();
        chk("R7", "still draining", {31'b0, stall_o}, 32'd1);
        tick(); cbuf_empty_i = 1; settle();
        chk("R7", "stall released", {31'b0, stall_o}, 32'd0);
        chk("R7", "no take", {31'b0, take_o}, 32'd0);
        tick(); settle();
        chk("R7", "still no take", {31'b0, take_o}, 32'd0);
        idle_inputs();
    endtask

    task automatic t_fault_abort();
        hi_base_i = 1;
        tick(); irq_req_i = 1; irq_en_i = 1; cbuf_empty_i = 0;
        tick();                       // DRAIN
        tick(); insn_exc_i = 1; cbuf_empty_i = 1; settle();
        chk("R8", "no take on fault cycle", {31'b0, take_o}, 32'd0);
        tick(); insn_exc_i = 0; cbuf_empty_i = 0; settle();
        chk("R8", "aborted, no take", {31'b0, take_o}, 32'd0);
        chk("R8", "re-evaluated stall", {31'b0, stall_o}, 32'd1);
        tick(); cbuf_empty_i = 1; settle();
        chk("R8", "draining again", {31'b0, stall_o}, 32'd1);
        tick(); irq_req_i = 0; settle();
        chk("R8", "retake after abort", {31'b0, take_o}, 32'd1);
        chk("R6", "high vector", vec_o, 32'hFFF0_0500);
        tick(); idle_inputs(); settle();
        chk("R10", "idle after retake", {31'b0, take_o}, 32'd0);
    endtask

    task automatic t_fault_idle();
        tick(); irq_req_i = 1; irq_en_i = 1; insn_exc_i = 1; settle();
        chk("R9", "no stall with fault", {31'b0, stall_o}, 32'd0);
        tick(); settle();
        chk("R9", "stayed idle", {31'b0, stall_o}, 32'd0);
        insn_exc_i = 0; settle();
        chk("R3", "stall once fault gone", {31'b0, stall_o}, 32'd1);
        tick(); irq_req_i = 0; settle();
        chk("R3", "entered drain", {31'b0, stall_o}, 32'd1);
        tick(); settle();
        chk("R7", "withdrawn", {31'b0, stall_o}, 32'd0);
        idle_inputs();
    endtask

    initial begin
        t_reset();
        t_basic(1'b0);
        t_basic(1'b1);
        t_disabled();
        t_withdraw();
        t_fault_abort();
        t_fault_idle();
        tick();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule